// File: doc/BRIEF.md
# Frame-Ready SPI Spectrum Result Streamer

This block sits between a transform engine and an external host. It stores one complete frame of complex spectrum bins. Each bin has a real and an imaginary 32-bit component. The engine writes bins through an indexed write port, in any order.

Once every bin index has been written, the block raises `frame_done`. The host is an SPI master. It pulls chip-select low and clocks the frame out in 8-bit transfers on MISO, using SPI mode 0. The host has no data to send, so the block has no MOSI input.

While `frame_done` is high, the stored frame is frozen and further engine writes are dropped. A single-cycle `frame_restart` pulse clears `frame_done` and the fill tracking, so the engine can produce the next frame. SCK and chip-select are asynchronous to `clk`. Both pass through two-flop synchronizers, and their edges are detected in the `clk` domain.

Top module: `spec_frame_spi_tx`

## Requirements
- R1: `frame_done` rises only when every bin index 0..NUM_BINS-1 has been written at least once since reset or the last restart. Writing the same index again does not count as another bin, and the last accepted write to an index is the value that is stored.
- R2: `frame_done` goes high on the same clock edge that accepts the write completing the set, so it is visible one cycle after that write strobe is presented.
- R3: Within one chip-select session, the byte stream visits bins in ascending index order. For each bin the real word comes first, then the imaginary word. Each word is sent most significant byte first, and each byte most significant bit first. A full frame is NUM_BINS*8 bytes.
- R4: SPI mode 0 timing. MISO changes only while SCK is low. The first bit is on MISO within 4 clk cycles of chip-select falling, and each following bit appears within 3 clk cycles of an SCK falling edge. The host keeps each SCK phase at least 4 clk cycles long.
- R5: While chip-select is high, MISO is driven 0. This holds from at most 4 clk cycles after chip-select rises.
- R6: Raising chip-select before the frame is finished returns the read position to bin 0, byte 0 for the next session. SPI activity never changes `frame_done`.
- R7: A `frame_restart` pulse clears `frame_done` and the fill tracking on the next clock edge. A write strobe presented in the same cycle as the pulse is discarded. A new frame is accepted after that.
- R8: Write strobes presented while `frame_done` is high are ignored. The frame being read keeps its contents.
- R9: After reset, `frame_done` is 0, no bins count as written, and MISO is 0.
- R10: If the host keeps clocking past the last byte of the frame in the same session, the stream wraps to bin 0, byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bin_wr_en | input | 1 | Write strobe from the transform engine |
| bin_wr_idx | input | $clog2(NUM_BINS) | Bin index being written |
| bin_wr_re | input | 32 | Real component of the bin |
| bin_wr_im | input | 32 | Imaginary component of the bin |
| frame_restart | input | 1 | One-cycle pulse that releases the frame and re-arms filling |
| frame_done | output | 1 | High when a full frame is stored and readable |
| spi_sck | input | 1 | SPI serial clock from the host (mode 0) |
| spi_cs_n | input | 1 | SPI chip-select from the host, active low |
| spi_miso | output | 1 | Serial result data to the host |

## Verification
The frame is first filled in descending index order, with one bin written twice, so that a block which counts strobes instead of distinct indices, or which stores by arrival order, is exposed before and after readout. A complete session reads every byte and one more, which checks byte and word order, bit order and wrap-around. It also confirms that MISO holds steady through each high SCK phase. A session that is cut off partway, followed by a fresh one, tells a pointer that is reset on chip-select rising apart from one that carries on. Junk writes while the frame is done, and a write strobe that coincides with the restart pulse, separate dropped strobes from accepted ones: the bench looks at the streamed bytes and at exactly when `frame_done` rises afterwards.

// File: rtl/spec_stream_pkg.sv
package spec_stream_pkg;

    localparam int COMP_W        = 32;
    localparam int XFER_W        = 8;
    localparam int BYTES_PER_BIN = (2 * COMP_W) / XFER_W;
    localparam int SEL_W         = $clog2(BYTES_PER_BIN);
    localparam int BITCNT_W      = $clog2(XFER_W);

    typedef struct packed {
        logic [COMP_W-1:0] re;
        logic [COMP_W-1:0] im;
    } cbin_t;

    typedef enum logic {
        LINK_IDLE   = 1'b0,
        LINK_ACTIVE = 1'b1
    } link_st_t;

    // Byte sel of a bin, sel 0 = most significant byte of the real word.
    function automatic logic [XFER_W-1:0] bin_byte(cbin_t b, logic [SEL_W-1:0] sel);
        logic [2*COMP_W-1:0] flat;
        flat = b;
        flat = flat << (XFER_W * int'(sel));
        return flat[2*COMP_W-1 -: XFER_W];
    endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int             W       = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        rise = sync_q & ~prev_q;
        fall = ~sync_q & prev_q;
    end

endmodule

// File: rtl/frame_store.sv
module frame_store
    import spec_stream_pkg::*;
#(
    parameter  int NUM_BINS = 512,
    localparam int IDX_W    = $clog2(NUM_BINS),
    localparam int CNT_W    = $clog2(NUM_BINS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  cbin_t            wr_bin,
    input  logic             restart,
    input  logic [IDX_W-1:0] rd_idx,
    output cbin_t            rd_bin,
    output logic             done,
    output logic [CNT_W-1:0] fill_cnt
);

    cbin_t             mem [NUM_BINS];
    logic [NUM_BINS-1:0] seen_q;
    logic              accept;
    logic              first_hit;

    always_comb begin
        accept    = wr_en && !done && !restart;
        first_hit = accept && !seen_q[wr_idx];
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_idx] <= wr_bin;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            seen_q   <= '0;
            fill_cnt <= '0;
            done     <= 1'b0;
        end else if (first_hit) begin
            seen_q[wr_idx] <= 1'b1;
            fill_cnt       <= fill_cnt + 1'b1;
            if (fill_cnt == CNT_W'(NUM_BINS - 1)) begin
                done <= 1'b1;
            end
        end
    end

    assign rd_bin = mem[rd_idx];

endmodule

// File: rtl/spi_byte_tx.sv
module spi_byte_tx
    import spec_stream_pkg::*;
#(
    parameter  int NUM_BINS = 512,
    localparam int IDX_W    = $clog2(NUM_BINS),
    localparam int PTR_W    = IDX_W + SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             sck_rise,
    input  logic             sck_fall,
    input  cbin_t            rd_bin,
    output logic [IDX_W-1:0] rd_idx,
    output logic             miso
);

    link_st_t            link_q;
    logic [PTR_W-1:0]    ptr_q;
    logic [PTR_W-1:0]    fetch_ptr;
    logic [BITCNT_W-1:0] bit_cnt_q;
    logic [XFER_W-1:0]   shreg_q;
    logic [XFER_W-1:0]   fetch_byte;

    always_comb begin
        fetch_ptr  = cs_fall ? '0 : ptr_q + 1'b1;
        rd_idx     = fetch_ptr[PTR_W-1:SEL_W];
        fetch_byte = bin_byte(rd_bin, fetch_ptr[SEL_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst || cs_rise) begin
            link_q    <= LINK_IDLE;
            ptr_q     <= '0;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
        end else if (cs_fall) begin
            link_q    <= LINK_ACTIVE;
            ptr_q     <= '0;
            bit_cnt_q <= '0;
            shreg_q   <= fetch_byte;
        end else if (link_q == LINK_ACTIVE) begin
            if (sck_rise) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (sck_fall) begin
                if (bit_cnt_q == '0) begin
                    ptr_q   <= fetch_ptr;
                    shreg_q <= fetch_byte;
                end else begin
                    shreg_q <= shreg_q << 1;
                end
            end
        end
    end

    assign miso = shreg_q[XFER_W-1];

endmodule

// File: rtl/spec_frame_spi_tx.sv
module spec_frame_spi_tx
    import spec_stream_pkg::*;
#(
    parameter  int NUM_BINS = 512,
    localparam int IDX_W    = $clog2(NUM_BINS),
    localparam int CNT_W    = $clog2(NUM_BINS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bin_wr_en,
    input  logic [IDX_W-1:0]  bin_wr_idx,
    input  logic [COMP_W-1:0] bin_wr_re,
    input  logic [COMP_W-1:0] bin_wr_im,
    input  logic              frame_restart,
    output logic              frame_done,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    output logic              spi_miso
);

    localparam int            PIN_CS  = 1;
    localparam int            PIN_SCK = 0;
    localparam logic [1:0]    PIN_IDLE = 2'b10;

    cbin_t            wr_word;
    cbin_t            rd_word;
    logic [IDX_W-1:0] rd_idx;
    logic [CNT_W-1:0] fill_cnt;
    logic [1:0]       pin_rise;
    logic [1:0]       pin_fall;

    always_comb begin
        wr_word.re = bin_wr_re;
        wr_word.im = bin_wr_im;
    end

    edge_sync #(
        .W       (2),
        .RST_VAL (PIN_IDLE)
    ) u_pins (
        .clk      (clk),
        .rst      (rst),
        .async_in ({spi_cs_n, spi_sck}),
        .rise     (pin_rise),
        .fall     (pin_fall)
    );

    frame_store #(
        .NUM_BINS (NUM_BINS)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bin_wr_en),
        .wr_idx   (bin_wr_idx),
        .wr_bin   (wr_word),
        .restart  (frame_restart),
        .rd_idx   (rd_idx),
        .rd_bin   (rd_word),
        .done     (frame_done),
        .fill_cnt (fill_cnt)
    );

    spi_byte_tx #(
        .NUM_BINS (NUM_BINS)
    ) u_tx (
        .clk      (clk),
        .rst      (rst),
        .cs_fall  (pin_fall[PIN_CS]),
        .cs_rise  (pin_rise[PIN_CS]),
        .sck_rise (pin_rise[PIN_SCK]),
        .sck_fall (pin_fall[PIN_SCK]),
        .rd_bin   (rd_word),
        .rd_idx   (rd_idx),
        .miso     (spi_miso)
    );

endmodule

// File: rtl/spec_frame_spi_tx_chk.sv
module spec_frame_spi_tx_chk #(
    parameter  int NUM_BINS = 512,
    localparam int CNT_W    = $clog2(NUM_BINS + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             bin_wr_en,
    input logic             frame_restart,
    input logic             frame_done,
    input logic [CNT_W-1:0] fill_cnt,
    input logic             spi_sck,
    input logic             spi_cs_n,
    input logic             spi_miso
);

    assert_fill_bound_R1: assert property (@(posedge clk) disable iff (rst)
        fill_cnt <= CNT_W'(NUM_BINS));

    assert_done_means_full_R1: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (fill_cnt == CNT_W'(NUM_BINS)));

    assert_done_after_write_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_done) |-> $past(bin_wr_en));

    assert_miso_low_sck_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(spi_miso) |-> !spi_sck);

    assert_miso_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> !spi_miso);

    assert_done_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !frame_restart) |=> frame_done);

    assert_restart_clears_R7: assert property (@(posedge clk) disable iff (rst)
        frame_restart |=> (!frame_done && fill_cnt == '0));

endmodule

bind spec_frame_spi_tx spec_frame_spi_tx_chk #(
    .NUM_BINS (NUM_BINS)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bin_wr_en     (bin_wr_en),
    .frame_restart (frame_restart),
    .frame_done    (frame_done),
    .fill_cnt      (fill_cnt),
    .spi_sck       (spi_sck),
    .spi_cs_n      (spi_cs_n),
    .spi_miso      (spi_miso)
);

// File: tb/spec_frame_spi_tx_tb.sv
`timescale 1ns/1ps
module spec_frame_spi_tx_tb;

    localparam int NB    = 64;
    localparam int IW    = $clog2(NB);
    localparam int HP    = 6;
    localparam int FRAME = NB * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bin_wr_en = 1'b0;
    logic [IW-1:0] bin_wr_idx = '0;
    logic [31:0]   bin_wr_re = '0;
    logic [31:0]   bin_wr_im = '0;
    logic          frame_restart = 1'b0;
    logic          frame_done;
    logic          spi_sck = 1'b0;
    logic          spi_cs_n = 1'b1;
    logic          spi_miso;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] m_re [NB];
    logic [31:0] m_im [NB];

    always #2.5 clk = ~clk;

    spec_frame_spi_tx #(.NUM_BINS(NB)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .bin_wr_en     (bin_wr_en),
        .bin_wr_idx    (bin_wr_idx),
        .bin_wr_re     (bin_wr_re),
        .bin_wr_im     (bin_wr_im),
        .frame_restart (frame_restart),
        .frame_done    (frame_done),
        .spi_sck       (spi_sck),
        .spi_cs_n      (spi_cs_n),
        .spi_miso      (spi_miso)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat_re(int i, logic [31:0] seed);
        return (32'(i) * 32'h9E37_79B1) ^ seed;
    endfunction

    function automatic logic [31:0] pat_im(int i, logic [31:0] seed);
        return {seed[15:0], 16'(i)} ^ 32'hC3A5_0F00;
    endfunction

    function automatic logic [7:0] exp_byte(int k);
        logic [63:0] w;
        w = {m_re[(k / 8) % NB], m_im[(k / 8) % NB]};
        return w[63 - 8 * (k % 8) -: 8];
    endfunction

    task automatic write_bin(input int idx, input logic [31:0] re, input logic [31:0] im);
        bin_wr_en  = 1'b1;
        bin_wr_idx = IW'(idx);
        bin_wr_re  = re;
        bin_wr_im  = im;
        @(negedge clk);
        bin_wr_en  = 1'b0;
    endtask

    task automatic cs_begin();
        spi_cs_n = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic cs_end();
        spi_cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic spi_byte(output logic [7:0] b, output int unstable);
        logic held;
        b = '0;
        unstable = 0;
        for (int k = 0; k < 8; k++) begin
            repeat (HP) @(negedge clk);
            b    = {b[6:0], spi_miso};
            held = spi_miso;
            spi_sck = 1'b1;
            repeat (HP) @(negedge clk);
            if (spi_miso !== held) unstable++;
            spi_sck = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk("R9 done after reset", 64'(frame_done), 64'd0);
        chk("R9 miso after reset", 64'(spi_miso), 64'd0);
    endtask

    task automatic t_fill_reverse();
        write_bin(5, 32'hDEAD_BEEF, 32'h0BAD_F00D);
        for (int i = NB - 1; i >= 1; i--) begin
            m_re[i] = pat_re(i, 32'h1357_2468);
            m_im[i] = pat_im(i, 32'h1357_2468);
            write_bin(i, m_re[i], m_im[i]);
        end
        chk("R1 done low with one bin missing", 64'(frame_done), 64'd0);
        m_re[0] = pat_re(0, 32'h1357_2468);
        m_im[0] = pat_im(0, 32'h1357_2468);
        bin_wr_en  = 1'b1;
        bin_wr_idx = '0;
        bin_wr_re  = m_re[0];
        bin_wr_im  = m_im[0];
        chk("R2 done low while completing strobe presented", 64'(frame_done), 64'd0);
        @(negedge clk);
        bin_wr_en = 1'b0;
        chk("R2 done high one cycle after completing write", 64'(frame_done), 64'd1);
    endtask

    task automatic t_read_full();
        logic [7:0] b;
        int u;
        int bad_order = 0;
        int unstable_tot = 0;
        cs_begin();
        for (int k = 0; k < FRAME; k++) begin
            spi_byte(b, u);
            unstable_tot += u;
            if (b !== exp_byte(k)) begin
                bad_order++;
                chk("R3 stream byte", 64'(b), 64'(exp_byte(k)));
            end
        end
        chk("R3 whole frame byte mismatches", 64'(bad_order), 64'd0);
        spi_byte(b, u);
        unstable_tot += u;
        chk("R10 byte after last wraps to bin 0 byte 0", 64'(b), 64'(exp_byte(0)));
        chk("R4 miso stable during sck high", 64'(unstable_tot), 64'd0);
        cs_end();
        chk("R6 done unaffected by readout", 64'(frame_done), 64'd1);
    endtask

    task automatic t_idle_miso();
        int hi = 0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (spi_miso !== 1'b0) hi++;
        end
        chk("R5 miso low with cs high", 64'(hi), 64'd0);
    endtask

    task automatic t_abort();
        logic [7:0] b;
        int u;
        cs_begin();
        for (int k = 0; k < 11; k++) spi_byte(b, u);
        chk("R3 partial session byte 10", 64'(b), 64'(exp_byte(10)));
        for (int k = 0; k < 3; k++) begin
            repeat (HP) @(negedge clk);
            spi_sck = 1'b1;
            repeat (HP) @(negedge clk);
            spi_sck = 1'b0;
        end
        cs_end();
        chk("R5 miso low after abort", 64'(spi_miso), 64'd0);
        cs_begin();
        spi_byte(b, u);
        chk("R6 restart at bin 0 byte 0", 64'(b), 64'(exp_byte(0)));
        spi_byte(b, u);
        chk("R6 then bin 0 byte 1", 64'(b), 64'(exp_byte(1)));
        cs_end();
        chk("R6 done kept after abort", 64'(frame_done), 64'd1);
    endtask

    task automatic t_ignore_writes();
        logic [7:0] b;
        int u;
        int bad = 0;
        write_bin(0, 32'hFFFF_FFFF, 32'h0000_0000);
        write_bin(3, 32'h1111_1111, 32'h2222_2222);
        chk("R8 done stays high under writes", 64'(frame_done), 64'd1);
        cs_begin();
        for (int k = 0; k < 32; k++) begin
            spi_byte(b, u);
            if (b !== exp_byte(k)) bad++;
        end
        cs_end();
        chk("R8 stored bins unchanged by writes while done", 64'(bad), 64'd0);
    endtask

    task automatic t_restart();
        logic [7:0] b;
        int u;
        int bad = 0;
        frame_restart = 1'b1;
        bin_wr_en     = 1'b1;
        bin_wr_idx    = IW'(2);
        bin_wr_re     = 32'hAAAA_AAAA;
        bin_wr_im     = 32'h5555_5555;
        @(negedge clk);
        frame_restart = 1'b0;
        bin_wr_en     = 1'b0;
        chk("R7 done cleared after restart", 64'(frame_done), 64'd0);
        for (int i = 0; i < NB; i++) begin
            m_re[i] = pat_re(i, 32'hF0E1_D2C3);
            m_im[i] = pat_im(i, 32'hF0E1_D2C3);
            if (i != 2) write_bin(i, m_re[i], m_im[i]);
        end
        chk("R7 write during restart discarded", 64'(frame_done), 64'd0);
        write_bin(2, m_re[2], m_im[2]);
        chk("R7 new frame completes", 64'(frame_done), 64'd1);
        cs_begin();
        for (int k = 0; k < 32; k++) begin
            spi_byte(b, u);
            if (b !== exp_byte(k)) bad++;
        end
        cs_end();
        chk("R7 new frame contents streamed", 64'(bad), 64'd0);
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill_reverse();
        t_read_full();
        t_idle_miso();
        t_abort();
        t_ignore_writes();
        t_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule